// File: doc/BRIEF.md
# Two-Select Rate Sensor Serial Host

This block is the host side of a serial link to an angular-rate sensor that has two active-low select lines. The configuration select frames a short write that loads the sensor's control register. The read select frames a conversion read. The block drives one shared serial clock and one host-to-sensor data line, and it samples one sensor-to-host data line. A single request pulse starts each transaction. While a frame is in flight, the block reports busy and ignores any further requests.

A configuration request shifts an 8-bit control word out, most significant bit first. The word is exactly the last eight bits the sensor sees before its configuration select rises. A read request pulls the read select low, which starts the sensor's conversion, and then produces a fixed burst of serial clocks. From that burst the block takes the 14-bit result, which the sensor places on the line from the sixth falling clock edge onward. When the select is released, the result is presented both as the raw offset-binary code (midpoint 8192) and as a two's-complement value centred on zero. The serial clock timing, the select-to-first-edge setup and the gap between frames are all set in system-clock cycles by parameters.

Top module: `rate_spi_host`

## Requirements
- R1: While reset is high and in the first cycle after it, both selects are high, the serial clock is high, the outgoing data line is low, busy is low and the result strobe is low.
- R2: A configuration frame holds the configuration select low for exactly 8 serial clock cycles. The outgoing data line changes only on falling clock edges and carries the control word bit 7 first, so the last 8 bits a rising-edge sampler collects equal the word.
- R3: A read frame pulls the read select low before the first falling clock edge, gives exactly 22 serial clock cycles, and then returns the read select high with the clock high.
- R4: The result takes the sensor line at falling edges 6 through 19 of the read frame (edge 6 gives bit 13, edge 19 gives bit 0). The levels at all other edges do not affect it.
- R5: The result strobe is high for one system cycle, in the cycle the read select returns high. In that cycle the raw output holds the 14-bit code and the signed output holds the code minus 8192 (range -8192 to +8191).
- R6: At most one select is low at any time. When neither is low, the serial clock is high and the outgoing data line is low. The outgoing data line stays low throughout read frames.
- R7: The first falling clock edge comes exactly SETUP_CLKS system cycles after the select falls. Each clock phase (low or high) lasts HALF_CLKS system cycles.
- R8: After a select returns high, busy stays high for exactly GAP_CLKS further system cycles, and no select falls in that time.
- R9: A request sampled while busy is low is accepted, and busy is high from the next cycle. Requests sampled while busy is high start no frame and do not change the frame in progress.
- R10: If both requests are sampled in the same idle cycle, only the configuration frame runs and the read request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Start a configuration write (one-cycle pulse) |
| cfg_word | input | 8 | Control word for the configuration write |
| rd_req | input | 1 | Start a conversion read (one-cycle pulse) |
| busy | output | 1 | Transaction in flight, including the inter-frame gap |
| cfg_cs_n | output | 1 | Active-low configuration select |
| rd_cs_n | output | 1 | Active-low read select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Host-to-sensor data line |
| miso | input | 1 | Sensor-to-host data line |
| rd_valid | output | 1 | One-cycle strobe when a new result is presented |
| rd_raw | output | 14 | Offset-binary result code |
| rd_signed | output | 14 | Result minus 8192, two's complement |

## Verification
A configuration request and a read request can arrive in the same idle cycle. The bench raises both in one cycle with a distinctive control word. It passes if the sensor model latches that word and the count of completed read frames does not change. Requests can also overlap a running frame, including the gap after the select rises. The bench pulses both requests at several points during a read and checks that the scoreboard receives exactly one result and no extra frame.

// File: rtl/rate_spi_pkg.sv
package rate_spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } seq_state_t;

  typedef enum logic {
    XFER_CFG = 1'b0,
    XFER_RD  = 1'b1
  } xfer_kind_t;

endpackage

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import rate_spi_pkg::*;
#(
  parameter int HALF_CLKS  = 2,
  parameter int SETUP_CLKS = 3,
  parameter int GAP_CLKS   = 4,
  parameter int CFG_EDGES  = 8,
  parameter int RD_EDGES   = 22,
  parameter int EDGE_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_req,
  input  logic              rd_req,
  output logic              busy,
  output logic              cfg_cs_n,
  output logic              rd_cs_n,
  output logic              sclk,
  output xfer_kind_t        kind,
  output logic              load_cfg,
  output logic              load_rd,
  output logic              fall_ev,
  output logic [EDGE_W-1:0] fall_idx,
  output logic              done_ev
);

  localparam int CNT_W = $clog2(HALF_CLKS + SETUP_CLKS + GAP_CLKS + 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CLKS - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CLKS - 1);

  seq_state_t        st;
  xfer_kind_t        kind_q;
  logic [CNT_W-1:0]  cnt;
  logic [EDGE_W-1:0] edges;
  logic [EDGE_W-1:0] frame_len;
  logic              cnt_zero;
  logic              last_edge;

  assign cnt_zero  = (cnt == '0);
  assign frame_len = (kind_q == XFER_CFG) ? EDGE_W'(CFG_EDGES) : EDGE_W'(RD_EDGES);
  assign last_edge = (edges == frame_len);
  assign load_cfg  = (st == ST_IDLE) && cfg_req;
  assign load_rd   = (st == ST_IDLE) && rd_req && !cfg_req;
  assign fall_ev   = cnt_zero && ((st == ST_SETUP) || ((st == ST_HIGH) && !last_edge));
  assign done_ev   = cnt_zero && (st == ST_HIGH) && last_edge;
  assign fall_idx  = edges + 1'b1;
  assign kind      = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind_q   <= XFER_RD;
      cnt      <= '0;
      edges    <= '0;
      busy     <= 1'b0;
      cfg_cs_n <= 1'b1;
      rd_cs_n  <= 1'b1;
      sclk     <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load_cfg || load_rd) begin
            kind_q   <= load_cfg ? XFER_CFG : XFER_RD;
            cfg_cs_n <= !load_cfg;
            rd_cs_n  <= !load_rd;
            busy     <= 1'b1;
            edges    <= '0;
            cnt      <= SETUP_LD;
            st       <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            st    <= ST_LOW;
            sclk  <= 1'b0;
            edges <= fall_idx;
            cnt   <= HALF_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt_zero) begin
            st   <= ST_HIGH;
            sclk <= 1'b1;
            cnt  <= HALF_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            if (last_edge) begin
              st       <= ST_GAP;
              cfg_cs_n <= 1'b1;
              rd_cs_n  <= 1'b1;
              cnt      <= GAP_LD;
            end else begin
              st    <= ST_LOW;
              sclk  <= 1'b0;
              edges <= fall_idx;
              cnt   <= HALF_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: never both selects low at once
  a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
    !(!cfg_cs_n && !rd_cs_n));

  // R6: clock parked high whenever no select is active
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    (cfg_cs_n && rd_cs_n) |-> sclk);

  // R9: an accepted request raises busy and drops exactly one select
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (load_cfg || load_rd) |=> (busy && $fell(cfg_cs_n && rd_cs_n)));

  // R9: transaction kind cannot change while a frame is running
  a_r9_kind_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && !(st == ST_GAP && cnt_zero)) |=> $stable(kind_q));

  // R3: edge counter never passes the longest frame
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (rst)
    edges <= EDGE_W'(RD_EDGES));

  // R8: during the gap the selects are released while busy remains
  a_r8_gap_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP) |-> (cfg_cs_n && rd_cs_n && busy));

endmodule

// File: rtl/spi_ctrl_tx.sv
module spi_ctrl_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              fall_ev,
  input  logic              is_cfg,
  input  logic              done_ev,
  output logic              mosi
);

  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      mosi <= 1'b0;
    end else begin
      if (load) begin
        sh <= word;
      end else if (fall_ev && is_cfg) begin
        mosi <= sh[WORD_W-1];
        sh   <= {sh[WORD_W-2:0], 1'b0};
      end
      if (done_ev) begin
        mosi <= 1'b0;
      end
    end
  end

  // R2: data line moves only on a falling clock edge or at frame end
  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (!fall_ev && !done_ev) |=> $stable(mosi));

  // R6: data line stays low outside configuration transfers
  a_r6_read_quiet: assert property (@(posedge clk) disable iff (rst)
    !is_cfg |-> !mosi);

endmodule

// File: rtl/spi_rate_rx.sv
module spi_rate_rx #(
  parameter int EDGE_W     = 5,
  parameter int DATA_FIRST = 6,
  parameter int DATA_BITS  = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fall_ev,
  input  logic [EDGE_W-1:0]           fall_idx,
  input  logic                        is_rd,
  input  logic                        done_ev,
  input  logic                        miso,
  output logic                        rd_valid,
  output logic [DATA_BITS-1:0]        rd_raw,
  output logic signed [DATA_BITS-1:0] rd_signed
);

  localparam int NW = $clog2(DATA_BITS + 1);
  localparam logic [EDGE_W-1:0] WIN_LO = EDGE_W'(DATA_FIRST);
  localparam logic [EDGE_W-1:0] WIN_HI = EDGE_W'(DATA_FIRST + DATA_BITS);

  logic [DATA_BITS-1:0] sh;
  logic [NW-1:0]        nsh;
  logic                 in_win;

  assign in_win = fall_ev && is_rd && (fall_idx >= WIN_LO) && (fall_idx < WIN_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      nsh       <= '0;
      rd_valid  <= 1'b0;
      rd_raw    <= '0;
      rd_signed <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (in_win) begin
        sh  <= {sh[DATA_BITS-2:0], miso};
        nsh <= nsh + 1'b1;
      end
      if (done_ev && is_rd) begin
        rd_valid  <= 1'b1;
        rd_raw    <= sh;
        rd_signed <= {~sh[DATA_BITS-1], sh[DATA_BITS-2:0]};
        nsh       <= '0;
      end
    end
  end

  // R4: exactly one full data word gathered per read frame
  a_r4_full_word: assert property (@(posedge clk) disable iff (rst)
    (done_ev && is_rd) |-> (nsh == NW'(DATA_BITS)));

  // R5: strobe lasts a single cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R5: signed view is the raw code less the midpoint
  a_r5_signed_offset: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (($signed({1'b0, rd_raw}) - $signed((DATA_BITS+1)'(1 << (DATA_BITS-1))))
                  == $signed({rd_signed[DATA_BITS-1], rd_signed})));

endmodule

// File: rtl/rate_spi_host.sv
module rate_spi_host
  import rate_spi_pkg::*;
#(
  parameter int HALF_CLKS  = 2,
  parameter int SETUP_CLKS = 3,
  parameter int GAP_CLKS   = 4,
  parameter int CFG_BITS   = 8,
  parameter int RD_EDGES   = 22,
  parameter int DATA_FIRST = 6,
  parameter int DATA_BITS  = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_req,
  input  logic [CFG_BITS-1:0]         cfg_word,
  input  logic                        rd_req,
  output logic                        busy,
  output logic                        cfg_cs_n,
  output logic                        rd_cs_n,
  output logic                        sclk,
  output logic                        mosi,
  input  logic                        miso,
  output logic                        rd_valid,
  output logic [DATA_BITS-1:0]        rd_raw,
  output logic signed [DATA_BITS-1:0] rd_signed
);

  localparam int EDGE_W = $clog2(RD_EDGES + 1);

  xfer_kind_t        kind;
  logic              load_cfg;
  logic              load_rd;
  logic              fall_ev;
  logic [EDGE_W-1:0] fall_idx;
  logic              done_ev;

  spi_frame_seq #(
    .HALF_CLKS (HALF_CLKS),
    .SETUP_CLKS(SETUP_CLKS),
    .GAP_CLKS  (GAP_CLKS),
    .CFG_EDGES (CFG_BITS),
    .RD_EDGES  (RD_EDGES),
    .EDGE_W    (EDGE_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cfg_req (cfg_req),
    .rd_req  (rd_req),
    .busy    (busy),
    .cfg_cs_n(cfg_cs_n),
    .rd_cs_n (rd_cs_n),
    .sclk    (sclk),
    .kind    (kind),
    .load_cfg(load_cfg),
    .load_rd (load_rd),
    .fall_ev (fall_ev),
    .fall_idx(fall_idx),
    .done_ev (done_ev)
  );

  spi_ctrl_tx #(
    .WORD_W(CFG_BITS)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load   (load_cfg),
    .word   (cfg_word),
    .fall_ev(fall_ev),
    .is_cfg (kind == XFER_CFG),
    .done_ev(done_ev),
    .mosi   (mosi)
  );

  spi_rate_rx #(
    .EDGE_W    (EDGE_W),
    .DATA_FIRST(DATA_FIRST),
    .DATA_BITS (DATA_BITS)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .fall_ev  (fall_ev),
    .fall_idx (fall_idx),
    .is_rd    (kind == XFER_RD),
    .done_ev  (done_ev),
    .miso     (miso),
    .rd_valid (rd_valid),
    .rd_raw   (rd_raw),
    .rd_signed(rd_signed)
  );

  // R10: a simultaneous pair of requests is resolved to the configuration frame
  a_r10_cfg_wins: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_req && rd_req) |=> (!cfg_cs_n && rd_cs_n));

endmodule

// File: tb/rate_spi_host_test.sv
module rate_spi_host_test;

  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int GAP   = 4;
  localparam int CFGB  = 8;
  localparam int RDE   = 22;
  localparam int FIRST = 6;
  localparam int DB    = 14;
  localparam int MID   = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cfg_req = 1'b0;
  logic [7:0]    cfg_word = 8'h00;
  logic          rd_req = 1'b0;
  logic          miso = 1'b0;
  logic          busy, cfg_cs_n, rd_cs_n, sclk, mosi, rd_valid;
  logic [DB-1:0] rd_raw;
  logic signed [DB-1:0] rd_signed;

  rate_spi_host uut (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_word(cfg_word), .rd_req(rd_req),
    .busy(busy), .cfg_cs_n(cfg_cs_n), .rd_cs_n(rd_cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .rd_valid(rd_valid), .rd_raw(rd_raw), .rd_signed(rd_signed)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit armed = 1'b0;

  typedef struct {
    bit            is_rd;
    logic [DB-1:0] code;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // sensor model
  logic [DB-1:0] sens_code = '0;
  int rd_rises = 0;
  int cfg_rises = 0;
  logic [7:0] cfg_sh = '0;
  int rd_frames = 0;
  int cfg_frames = 0;

  function automatic logic miso_for(input int k);
    if (k >= FIRST && k < FIRST + DB) return sens_code[DB-1-(k-FIRST)];
    return 1'((k % 2) == 0);
  endfunction

  always @(negedge rd_cs_n) if (armed) begin
    rd_rises = 0;
    miso = miso_for(1);
  end

  always @(negedge cfg_cs_n) if (armed) cfg_rises = 0;

  always @(posedge sclk) if (armed) begin
    if (rd_cs_n === 1'b0) begin
      rd_rises++;
      miso = miso_for(rd_rises + 1);
    end
    if (cfg_cs_n === 1'b0) begin
      cfg_rises++;
      cfg_sh = {cfg_sh[6:0], mosi};
    end
  end

  always @(posedge rd_cs_n) if (armed) begin
    rd_frames++;
    check(rd_rises == RDE, "R3", "read clock count", rd_rises, RDE);
  end

  always @(posedge cfg_cs_n) if (armed) begin
    exp_t e;
    cfg_frames++;
    check(cfg_rises == CFGB, "R2", "config clock count", cfg_rises, CFGB);
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", "unexpected config frame", 1, 0);
    end else begin
      e = exp_q.pop_front();
      check(!e.is_rd, "R10", "config frame where read expected", 0, 1);
      check(cfg_sh == e.code[7:0], "R2", "latched control word", int'(cfg_sh), int'(e.code[7:0]));
    end
  end

  // monitor
  int sel_viol = 0;
  int idle_viol = 0;
  int setup_cnt = 0;
  bit seen_fall = 1'b0;
  int low_cnt = 0;
  int gap_cnt = 0;
  logic prev_rd_cs = 1'b1;
  logic prev_valid = 1'b0;

  always @(negedge clk) if (armed) begin
    if (!cfg_cs_n && !rd_cs_n) sel_viol++;
    if (cfg_cs_n && rd_cs_n && (sclk !== 1'b1 || mosi !== 1'b0)) idle_viol++;
    if (!rd_cs_n && mosi !== 1'b0) idle_viol++;

    if (!cfg_cs_n || !rd_cs_n) begin
      if (!seen_fall) begin
        if (sclk) setup_cnt++;
        else begin
          seen_fall = 1'b1;
          check(setup_cnt == SETUP, "R7", "select to first fall", setup_cnt, SETUP);
        end
      end
      if (!rd_cs_n && !sclk) low_cnt++;
    end else begin
      setup_cnt = 0;
      seen_fall = 1'b0;
    end

    if (cfg_cs_n && rd_cs_n && busy) gap_cnt++;
    else if (!busy && gap_cnt > 0) begin
      check(gap_cnt == GAP, "R8", "gap length", gap_cnt, GAP);
      gap_cnt = 0;
    end

    if (rd_valid) begin
      exp_t e;
      check(prev_valid == 1'b0, "R5", "strobe width", 2, 1);
      check(rd_cs_n && !prev_rd_cs, "R5", "strobe on select release", int'(rd_cs_n), 1);
      check(low_cnt == RDE * HALF, "R7", "clock low cycles", low_cnt, RDE * HALF);
      low_cnt = 0;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected read result", int'(rd_raw), 0);
      end else begin
        e = exp_q.pop_front();
        check(e.is_rd, "R10", "read frame where config expected", 1, 0);
        check(rd_raw == e.code, "R4", "raw code", int'(rd_raw), int'(e.code));
        check(int'(rd_signed) == int'(e.code) - MID, "R5", "signed value",
              int'(rd_signed), int'(e.code) - MID);
      end
    end
    prev_valid = rd_valid;
    prev_rd_cs = rd_cs_n;
  end

  // driver
  task automatic issue(input bit c, input bit r, input logic [7:0] w);
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_word = w;
    cfg_req = c;
    rd_req = r;
    @(negedge clk);
    cfg_req = 1'b0;
    rd_req = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input logic [DB-1:0] code);
    exp_t e;
    sens_code = code;
    e.is_rd = 1'b1;
    e.code = code;
    exp_q.push_back(e);
    issue(1'b0, 1'b1, 8'h00);
  endtask

  task automatic do_cfg(input logic [7:0] w);
    exp_t e;
    e.is_rd = 1'b0;
    e.code = DB'(w);
    exp_q.push_back(e);
    issue(1'b1, 1'b0, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int rd0;
    int cf0;
    repeat (4) @(negedge clk);
    check(cfg_cs_n && rd_cs_n, "R1", "selects in reset", int'({cfg_cs_n, rd_cs_n}), 3);
    check(sclk && !mosi, "R1", "clock/data in reset", int'({sclk, mosi}), 2);
    check(!busy && !rd_valid, "R1", "busy/strobe in reset", int'({busy, rd_valid}), 0);
    rst = 1'b0;
    armed = 1'b1;
    @(negedge clk);
    check(cfg_cs_n && rd_cs_n && sclk && !busy, "R1", "first cycle after reset",
          int'({cfg_cs_n, rd_cs_n, sclk, busy}), 14);

    // R4 R5: several codes, including midpoint and both extremes
    do_read(14'd8192);
    do_read(14'd0);
    do_read(14'd16383);
    do_read(14'd9018);
    do_read(14'd7365);
    do_read(14'h2AAA);
    // R2: control words
    do_cfg(8'b0010_0000);
    do_cfg(8'b1000_0001);
    do_cfg(8'h5A);

    // R9: requests during a frame and during the gap are ignored
    rd0 = rd_frames;
    cf0 = cfg_frames;
    begin
      exp_t e;
      sens_code = 14'h1234;
      e.is_rd = 1'b1;
      e.code = 14'h1234;
      exp_q.push_back(e);
    end
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (10) @(negedge clk);
    cfg_req = 1'b1;
    cfg_word = 8'hFF;
    rd_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    rd_req = 1'b0;
    @(posedge rd_cs_n);
    @(negedge clk);
    rd_req = 1'b1;
    cfg_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    cfg_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (60) @(negedge clk);
    check(rd_frames == rd0 + 1, "R9", "read frames after busy requests", rd_frames, rd0 + 1);
    check(cfg_frames == cf0, "R9", "config frames after busy requests", cfg_frames, cf0);

    // R10: both requests together
    rd0 = rd_frames;
    begin
      exp_t e;
      e.is_rd = 1'b0;
      e.code = DB'(8'hA5);
      exp_q.push_back(e);
    end
    issue(1'b1, 1'b1, 8'hA5);
    repeat (60) @(negedge clk);
    check(rd_frames == rd0, "R10", "read dropped on tie", rd_frames, rd0);

    do_read(14'd1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9", "outstanding expectations", exp_q.size(), 0);
    check(sel_viol == 0, "R6", "both selects low", sel_viol, 0);
    check(idle_viol == 0, "R6", "idle clock/data level", idle_viol, 0);
    finish_run();
  end

endmodule